// File: doc/BRIEF.md
# Sequential Shift-and-Add Multiplier

This block multiplies two unsigned operands of `WIDTH` bits and returns the full product of `2*WIDTH` bits. It spends one clock per multiplier bit, so the hardware holds one double-width adder and no array of partial products. A caller pulses `start_i` with both operands present. After `WIDTH` accumulate cycles the block pulses `done_o` and leaves the product on `product_o` until the next accepted start.

Three registers do the work. The multiplicand register is double width: it loads the operand zero-extended into its lower half and moves one place left each cycle. The multiplier register loads the other operand and moves one place right each cycle. The product register does not shift. When the multiplier's lowest bit is 1, the product register takes the sum of itself and the current multiplicand. When that bit is 0, it keeps its value. A small controller counts the iterations and rejects a start that arrives while a multiply is in progress.

Top module: `seqmul_core`

## Requirements
- R1: While reset (`rst_n` low) is applied and after it is released, `product_o` reads 0 and `done_o` reads 0 until the first accepted start completes.
- R2: For any unsigned operands, the value on `product_o` while `done_o` is high equals `opa_i * opb_i` as sampled at the accepted start. The value is exact in `2*WIDTH` bits.
- R3: If start is accepted at rising edge k, `done_o` is high for the clock cycle that follows edge k+WIDTH, and is low again after edge k+WIDTH+1.
- R4: Outside a running multiply, `product_o` keeps its value on every edge at which no start is accepted.
- R5: A `start_i` pulse that arrives while a multiply is in progress has no effect. The running multiply finishes at its original time with its original result, and no extra `done_o` pulse follows.
- R6: An accepted start clears the product register, so `product_o` reads 0 in the cycle right after the start edge.
- R7: The block gives exact results both with `WIDTH` = 4 (8-bit product) and with `WIDTH` = 32 (64-bit product).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request a multiply. Accepted only when idle |
| opa_i | input | WIDTH | Multiplicand, sampled at an accepted start |
| opb_i | input | WIDTH | Multiplier, sampled at an accepted start |
| done_o | output | 1 | One-cycle pulse when the product is complete |
| product_o | output | 2*WIDTH | Unsigned product, held while idle |

## Verification
The bench targets the operand corners zero, one and all-ones, alone and in combination. A design that drops the top carry or shifts the multiplicand one step too few would give a wrong all-ones times all-ones result. A design that does not clear the product register would carry the previous result into the next one. It runs every 4-bit pair and a spread of random 32-bit pairs, and checks that the done pulse lands on the exact edge. An off-by-one counter would move that edge or truncate the last partial product. A second start during a run would, in a faulty design, reload the operands and either change the result or produce a second done pulse; the bench's empty-queue check reports that extra pulse.

// File: rtl/smul_pkg.sv
package smul_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/smul_mplr_sr.sv
module smul_mplr_sr #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic [WIDTH-1:0] din_i,
  output logic             lsb_o,
  output logic [WIDTH-1:0] bits_o
);
  logic [WIDTH-1:0] mplr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       mplr_q <= '0;
    else if (load_i)  mplr_q <= din_i;
    else if (shift_i) mplr_q <= mplr_q >> 1;
  end

  assign lsb_o  = mplr_q[0];
  assign bits_o = mplr_q;
endmodule

// File: rtl/smul_mcand_sr.sv
module smul_mcand_sr #(
  parameter int WIDTH = 32,
  localparam int PW = 2 * WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic [WIDTH-1:0] din_i,
  output logic [PW-1:0]    q_o
);
  logic [PW-1:0] mcand_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       mcand_q <= '0;
    else if (load_i)  mcand_q <= {{WIDTH{1'b0}}, din_i};
    else if (shift_i) mcand_q <= mcand_q << 1;
  end

  assign q_o = mcand_q;
endmodule

// File: rtl/smul_accum.sv
module smul_accum #(
  parameter int WIDTH = 32,
  localparam int PW = 2 * WIDTH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          step_i,
  input  logic          take_i,
  input  logic [PW-1:0] addend_i,
  output logic [PW-1:0] prod_o
);
  // Sum with one extra bit so that a lost carry is visible.
  function automatic logic [PW:0] partial_sum(input logic [PW-1:0] acc,
                                              input logic [PW-1:0] addend,
                                              input logic take);
    if (take) return {1'b0, acc} + {1'b0, addend};
    return {1'b0, acc};
  endfunction

  logic [PW-1:0] prod_q;
  logic [PW:0]   sum_w;
  logic          carry_w;

  assign sum_w   = partial_sum(prod_q, addend_i, take_i);
  assign carry_w = sum_w[PW];

  always_ff @(posedge clk) begin
    if (!rst_n)      prod_q <= '0;
    else if (clr_i)  prod_q <= '0;
    else if (step_i) prod_q <= sum_w[PW-1:0];
  end

  assign prod_o = prod_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && take_i) |-> !carry_w); // R2
endmodule

// File: rtl/smul_ctrl.sv
module smul_ctrl #(
  parameter int WIDTH = 32,
  localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic accept_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  import smul_pkg::*;

  seq_state_e       state_q;
  logic [CNT_W-1:0] iter_q;
  logic             done_q;
  logic             last_w;

  assign last_w   = (iter_q == CNT_W'(WIDTH - 1));
  assign accept_o = start_i && (state_q == SEQ_IDLE);
  assign step_o   = (state_q == SEQ_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      iter_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept_o) begin
        state_q <= SEQ_RUN;
        iter_q  <= '0;
      end else if (state_q == SEQ_RUN) begin
        iter_q <= iter_q + CNT_W'(1);
        if (last_w) begin
          state_q <= SEQ_IDLE;
          done_q  <= 1'b1;
        end
      end
    end
  end

  assign busy_o = (state_q == SEQ_RUN);
  assign done_o = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R3
  AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(state_q == SEQ_RUN)); // R3
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_RUN && !last_w) |=> (state_q == SEQ_RUN && iter_q == $past(iter_q) + CNT_W'(1))); // R5
endmodule

// File: rtl/seqmul_core.sv
module seqmul_core #(
  parameter int WIDTH = 32,
  localparam int PW = 2 * WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  output logic             done_o,
  output logic [PW-1:0]    product_o
);
  logic             accept_w;
  logic             step_w;
  logic             busy_w;
  logic             mplr_lsb_w;
  logic [WIDTH-1:0] mplr_bits_w;
  logic [PW-1:0]    mcand_w;

  smul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .accept_o(accept_w), .step_o(step_w), .busy_o(busy_w), .done_o(done_o)
  );

  smul_mplr_sr #(.WIDTH(WIDTH)) u_mplr (
    .clk(clk), .rst_n(rst_n), .load_i(accept_w), .shift_i(step_w),
    .din_i(opb_i), .lsb_o(mplr_lsb_w), .bits_o(mplr_bits_w)
  );

  smul_mcand_sr #(.WIDTH(WIDTH)) u_mcand (
    .clk(clk), .rst_n(rst_n), .load_i(accept_w), .shift_i(step_w),
    .din_i(opa_i), .q_o(mcand_w)
  );

  smul_accum #(.WIDTH(WIDTH)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr_i(accept_w), .step_i(step_w),
    .take_i(mplr_lsb_w), .addend_i(mcand_w), .prod_o(product_o)
  );

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_w && !start_i) |=> $stable(product_o)); // R4
  AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> (product_o == '0)); // R6
  AST_MPLR_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (mplr_bits_w == '0)); // R2
endmodule

// File: tb/seqmul_core_test.sv
module seqmul_core_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic        st32 = 1'b0, st4 = 1'b0;
  logic [31:0] a32 = '0, b32 = '0;
  logic [3:0]  a4 = '0, b4 = '0;
  logic        done32, done4;
  logic [63:0] p32;
  logic [7:0]  p4;

  seqmul_core uut (.clk(clk), .rst_n(rst_n), .start_i(st32), .opa_i(a32),
                   .opb_i(b32), .done_o(done32), .product_o(p32));
  seqmul_core #(.WIDTH(4)) uut4 (.clk(clk), .rst_n(rst_n), .start_i(st4),
                   .opa_i(a4), .opb_i(b4), .done_o(done4), .product_o(p4));

  logic [63:0] q32_val[$];
  int          q32_cyc[$];
  logic [7:0]  q4_val[$];
  int          q4_cyc[$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: WIDTH=32 instance
  task automatic go32(input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    q32_val.push_back(64'(a) * 64'(b));
    q32_cyc.push_back(cyc + 1 + 32);
    a32 = a; b32 = b; st32 = 1'b1;
    @(negedge clk);
    st32 = 1'b0;
    chk(p32 == 64'd0, "R6 clear on start", p32, 64'd0);
    repeat (33) @(negedge clk);
  endtask

  // Driver: WIDTH=4 instance (R7)
  task automatic go4(input logic [3:0] a, input logic [3:0] b);
    @(negedge clk);
    q4_val.push_back(8'(a) * 8'(b));
    q4_cyc.push_back(cyc + 1 + 4);
    a4 = a; b4 = b; st4 = 1'b1;
    @(negedge clk);
    st4 = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  // Monitors
  logic d32_prev = 1'b0, d4_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (done32) begin
        if (d32_prev) chk(1'b0, "R3 done32 longer than one cycle", 64'(1), 64'(0));
        if (q32_val.size() == 0) chk(1'b0, "R5 unexpected done32", 64'(1), 64'(0));
        else begin
          logic [63:0] ev;
          int ec;
          ev = q32_val.pop_front();
          ec = q32_cyc.pop_front();
          chk(p32 == ev, "R2 product 32-bit", p32, ev);
          chk(cyc == ec, "R3 done32 timing", 64'(cyc), 64'(ec));
        end
      end
      if (done4) begin
        if (d4_prev) chk(1'b0, "R3 done4 longer than one cycle", 64'(1), 64'(0));
        if (q4_val.size() == 0) chk(1'b0, "R7 unexpected done4", 64'(1), 64'(0));
        else begin
          logic [7:0] ev4;
          int ec4;
          ev4 = q4_val.pop_front();
          ec4 = q4_cyc.pop_front();
          chk(p4 == ev4, "R7 product 4-bit", 64'(p4), 64'(ev4));
          chk(cyc == ec4, "R3 done4 timing", 64'(cyc), 64'(ec4));
        end
      end
    end
    d32_prev <= done32;
    d4_prev  <= done4;
  end

  initial begin : watchdog
    wait (cyc == 150000);
    chk(1'b0, "watchdog expired", 64'(cyc), 64'(0));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [63:0] held;
    repeat (3) @(negedge clk);
    chk(p32 == 64'd0 && !done32, "R1 reset state 32", p32, 64'd0);
    chk(p4 == 8'd0 && !done4, "R1 reset state 4", 64'(p4), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(p32 == 64'd0 && !done32, "R1 after release", p32, 64'd0);

    // R2 corners
    go32(32'd0, 32'd0);
    go32(32'd0, 32'hFFFF_FFFF);
    go32(32'hFFFF_FFFF, 32'd0);
    go32(32'd1, 32'd1);
    go32(32'd1, 32'hFFFF_FFFF);
    go32(32'hFFFF_FFFF, 32'd1);
    go32(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    go32(32'h8000_0000, 32'h8000_0000);
    for (int i = 0; i < 40; i++) go32($urandom, $urandom);

    // R4: product held while idle
    held = p32;
    repeat (10) @(negedge clk);
    chk(p32 == held, "R4 hold while idle", p32, held);

    // R5: second start during a run is ignored
    @(negedge clk);
    q32_val.push_back(64'(32'h1234_5678) * 64'(32'h9ABC_DEF0));
    q32_cyc.push_back(cyc + 1 + 32);
    a32 = 32'h1234_5678; b32 = 32'h9ABC_DEF0; st32 = 1'b1;
    @(negedge clk);
    st32 = 1'b0;
    repeat (5) @(negedge clk);
    a32 = 32'hFFFF_FFFF; b32 = 32'h0000_0003; st32 = 1'b1;
    @(negedge clk);
    st32 = 1'b0;
    repeat (40) @(negedge clk);
    chk(p32 == 64'(32'h1234_5678) * 64'(32'h9ABC_DEF0), "R5 result after ignored start",
        p32, 64'(32'h1234_5678) * 64'(32'h9ABC_DEF0));

    // R7: exhaustive 4-bit
    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++) go4(4'(x), 4'(y));

    repeat (5) @(negedge clk);
    chk(q32_val.size() == 0, "R3 all 32-bit results seen", 64'(q32_val.size()), 64'd0);
    chk(q4_val.size() == 0, "R7 all 4-bit results seen", 64'(q4_val.size()), 64'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule